// File: doc/BRIEF.md
# Multi-source OTN frame builder

This block assembles the transmit-side frame stream of an optical transport framer. On every enabled clock cycle it emits one 48-bit word, six bytes with the most significant byte sent first. It takes payload words from four 48-bit source streams, and it produces the overhead itself: the alignment word, the multiframe count and a routing code. The FEC region is filled with zeros. A scrambler and the real FEC encoder sit downstream and are not part of this block.

A frame is four rows. Each row holds 16 overhead bytes, then the payload region, then the FEC region, and a row is an exact number of words. With the default sizes a row is 4080 bytes, or 680 words. Because the 16-byte overhead does not end on a word boundary, payload bytes run two bytes behind the source words. A 32-bit holding register joins the tail of one source word to the head of the next. The block pulls source words through one-hot read strobes, which expect first-word-fall-through FIFOs. It marks the frame start, the first payload word of each row and the frame end with single-cycle strobes.

Top module: `otn_frame_builder`

## Requirements
- R1: While reset is active and just after it is released, `frm_valid`, `frm_sof`, `frm_sod`, `frm_eof` and `src_rd` are all 0 and `frm_data` is zero.
- R2: A row is (16 + PAY_BYTES + FEC_BYTES)/6 words and a frame is 4 rows. `frm_sof` is high on word 0 of row 0, `frm_sod` is high on word 2 of every row, and `frm_eof` is high on the last word of row 3. All three are low on every other output word.
- R3: Word 0 of row 0 equals FAW (default 0xF6F6F6282828). Word 0 of rows 1 to 3 is zero.
- R4: Overhead bytes are numbered 0 to 15 within the row. Byte 10 of row 0 holds the routing code in its low 5 bits, with its upper 3 bits zero. Every other overhead byte after byte 5 is zero, apart from byte 6 of row 0 (R5).
- R5: Byte 6 of row 0 carries the multiframe count. The count is 0 after reset, rises by one after each frame and wraps from 255 to 0.
- R6: Payload byte p of a row (p = 0 to PAY_BYTES-1, starting at row byte 16) is byte p mod 6 (byte 0 = bits 47:40) of the j-th source word read in that row, where j = p div 6. That word comes from source j mod 4. Rotation restarts at source 0 in every row. The last two bytes of the last word read in a row are dropped.
- R7: In the cycle that forms word k of a row, for 2 <= k <= (16+PAY_BYTES)/6 - 1, `src_rd` is one-hot on source (k-2) mod 4. In every other cycle it is zero. The data is taken from `src_data` in that same cycle.
- R8: Every FEC byte is zero. The word at index (16+PAY_BYTES)/6 carries two payload bytes followed by four zero bytes.
- R9: While `en` is low, `src_rd` is zero, the position does not advance and the next cycle shows `frm_valid` low with all strobes low. Output resumes at the stalled position.
- R10: The routing code is sampled only in the cycle that forms the alignment word. Changes at any other time affect only the next frame.
- R11: The first enabled cycle after reset emits the alignment word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance one word this cycle |
| route_code | input | RC_W (5) | Source-to-destination permutation code |
| src_data | input | 4 x 48 | Head word of each source FIFO, source 0 at index 0 |
| src_rd | output | 4 | One-hot read strobe toward the source FIFOs |
| frm_data | output | 48 | Frame word, first byte in bits 47:40 |
| frm_valid | output | 1 | `frm_data` holds a new word |
| frm_sof | output | 1 | First word of the frame |
| frm_sod | output | 1 | Word carrying the first payload bytes of a row |
| frm_eof | output | 1 | Last word of the frame |

## Verification
The assertions assume that every source FIFO holds a word whenever its strobe rises, so `src_data` is always meaningful when it is read. They place no limit on how `en` is toggled. The bench meets the first assumption with unbounded source models that present a fresh, distinct word after each pop. It drops `en` at several periods, including mid-row and inside the FEC region, and it changes the routing code on every cycle of one frame so that only the sample taken at the alignment word can show up in the header.

// File: rtl/otn_bld_pkg.sv
package otn_bld_pkg;

  localparam int unsigned OCT       = 8;
  localparam int unsigned WBYTES    = 6;
  localparam int unsigned WORD_W    = WBYTES * OCT;
  localparam int unsigned HDR_BYTES = 16;
  localparam int unsigned NROWS     = 4;
  localparam int unsigned NSRC      = 4;
  localparam int unsigned LEAD_W    = 2 * OCT;          // payload bytes in the header word
  localparam int unsigned TAIL_W    = WORD_W - LEAD_W;  // bytes carried to the next word
  localparam int unsigned MF_W      = 8;

  typedef enum logic [2:0] {
    RG_ALIGN,
    RG_HDR,
    RG_HDR_DAT,
    RG_DAT,
    RG_DAT_FEC,
    RG_FEC
  } region_e;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_ALIGN,
    ST_HDR,
    ST_HDR_DAT,
    ST_DAT0,
    ST_DAT1,
    ST_DAT2,
    ST_DAT3,
    ST_DAT_FEC,
    ST_FEC
  } bld_state_e;

  // Region of the row that a word index belongs to.
  function automatic region_e region_of(input int unsigned word,
                                        input int unsigned row,
                                        input int unsigned df_word);
    if (word == 0)            return (row == 0) ? RG_ALIGN : RG_HDR;
    else if (word == 1)       return RG_HDR;
    else if (word == 2)       return RG_HDR_DAT;
    else if (word < df_word)  return RG_DAT;
    else if (word == df_word) return RG_DAT_FEC;
    else                      return RG_FEC;
  endfunction

  // State seen from outside: the region, with data words split by source.
  function automatic bld_state_e state_of(input logic started,
                                          input region_e rg,
                                          input logic [1:0] sel);
    if (!started) return ST_WAIT;
    case (rg)
      RG_ALIGN:   return ST_ALIGN;
      RG_HDR:     return ST_HDR;
      RG_HDR_DAT: return ST_HDR_DAT;
      RG_DAT: begin
        case (sel)
          2'd0:    return ST_DAT0;
          2'd1:    return ST_DAT1;
          2'd2:    return ST_DAT2;
          default: return ST_DAT3;
        endcase
      end
      RG_DAT_FEC: return ST_DAT_FEC;
      default:    return ST_FEC;
    endcase
  endfunction

endpackage

// File: rtl/otn_bld_pos.sv
module otn_bld_pos
  import otn_bld_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 680,
  parameter int unsigned WCW       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [WCW-1:0]  word_cnt,
  output logic [1:0]      row_cnt,
  output logic [MF_W-1:0] mf_cnt,
  output logic            started,
  output logic            row_last,
  output logic            frame_last
);

  localparam logic [WCW-1:0] LAST_W   = WCW'(ROW_WORDS - 1);
  localparam logic [1:0]     LAST_ROW = 2'(NROWS - 1);

  assign row_last   = (word_cnt == LAST_W);
  assign frame_last = row_last && (row_cnt == LAST_ROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cnt <= '0;
      row_cnt  <= '0;
      mf_cnt   <= '0;
      started  <= 1'b0;
    end else if (adv) begin
      started <= 1'b1;
      if (row_last) begin
        word_cnt <= '0;
        row_cnt  <= row_cnt + 2'd1;
        if (frame_last) mf_cnt <= mf_cnt + 1'b1;
      end else begin
        word_cnt <= word_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/otn_bld_fetch.sv
module otn_bld_fetch
  import otn_bld_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch,
  input  logic [1:0]                  sel,
  input  logic [NSRC-1:0][WORD_W-1:0] src_data,
  output logic [NSRC-1:0]             src_rd,
  output logic [WORD_W-1:0]           new_word,
  output logic [TAIL_W-1:0]           hold_q
);

  for (genvar g = 0; g < NSRC; g++) begin : g_rd
    assign src_rd[g] = fetch && (sel == 2'(g));
  end

  assign new_word = src_data[sel];

  // The tail of the word just read, sent out with the next word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (fetch) hold_q <= new_word[TAIL_W-1:0];
  end

endmodule

// File: rtl/otn_bld_hdr.sv
module otn_bld_hdr
  import otn_bld_pkg::*;
#(
  parameter logic [WORD_W-1:0] FAW  = 48'hF6F6F6282828,
  parameter int unsigned       RC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic [RC_W-1:0]   route_in,
  input  logic [MF_W-1:0]   mf,
  input  region_e           rg,
  input  logic              word_is1,
  input  logic              row_is0,
  output logic [WORD_W-1:0] hdr_word
);

  logic [RC_W-1:0] route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     route_q <= '0;
    else if (latch) route_q <= route_in;
  end

  // Row 0, second word: multiframe byte, three monitoring bytes,
  // the routing byte, and one more zero byte.
  always_comb begin
    hdr_word = '0;
    case (rg)
      RG_ALIGN: hdr_word = FAW;
      RG_HDR:   if (word_is1 && row_is0)
                  hdr_word = {8'(mf), 24'h0, 8'(route_q), 8'h0};
      default:  hdr_word = '0;
    endcase
  end

endmodule

// File: rtl/otn_frame_builder.sv
module otn_frame_builder
  import otn_bld_pkg::*;
#(
  parameter int unsigned       PAY_BYTES = 3808,
  parameter int unsigned       FEC_BYTES = 256,
  parameter int unsigned       RC_W      = 5,
  parameter logic [WORD_W-1:0] FAW       = 48'hF6F6F6282828
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [RC_W-1:0]             route_code,
  input  logic [NSRC-1:0][WORD_W-1:0] src_data,
  output logic [NSRC-1:0]             src_rd,
  output logic [WORD_W-1:0]           frm_data,
  output logic                        frm_valid,
  output logic                        frm_sof,
  output logic                        frm_sod,
  output logic                        frm_eof
);

  // PAY_BYTES and FEC_BYTES must each be 4 mod 6.
  localparam int unsigned ROW_BYTES = HDR_BYTES + PAY_BYTES + FEC_BYTES;
  localparam int unsigned ROW_WORDS = ROW_BYTES / WBYTES;
  localparam int unsigned DF_WORD   = (HDR_BYTES + PAY_BYTES) / WBYTES;
  localparam int unsigned WCW       = $clog2(ROW_WORDS);

  logic [WCW-1:0]  word_cnt;
  logic [1:0]      row_cnt;
  logic [MF_W-1:0] mf_cnt;
  logic            started;
  logic            row_last;
  logic            frame_last;

  // Named events for the checker.
  region_e         rg;
  bld_state_e      cur_state;
  logic            fetch;
  logic            frame_done;
  logic [1:0]      sel;
  logic [WCW-1:0]  wm2;

  logic [WORD_W-1:0] new_word;
  logic [TAIL_W-1:0] hold_q;
  logic [WORD_W-1:0] hdr_word;
  logic [WORD_W-1:0] word_nxt;

  otn_bld_pos #(.ROW_WORDS(ROW_WORDS), .WCW(WCW)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (en),
    .word_cnt   (word_cnt),
    .row_cnt    (row_cnt),
    .mf_cnt     (mf_cnt),
    .started    (started),
    .row_last   (row_last),
    .frame_last (frame_last)
  );

  assign rg         = region_of(32'(word_cnt), 32'(row_cnt), DF_WORD);
  assign wm2        = word_cnt - WCW'(2);
  assign sel        = wm2[1:0];
  assign fetch      = en && (rg == RG_HDR_DAT || rg == RG_DAT);
  assign frame_done = en && frame_last;
  assign cur_state  = state_of(started, rg, sel);

  otn_bld_fetch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch    (fetch),
    .sel      (sel),
    .src_data (src_data),
    .src_rd   (src_rd),
    .new_word (new_word),
    .hold_q   (hold_q)
  );

  otn_bld_hdr #(.FAW(FAW), .RC_W(RC_W)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch    (en && rg == RG_ALIGN),
    .route_in (route_code),
    .mf       (mf_cnt),
    .rg       (rg),
    .word_is1 (word_cnt == WCW'(1)),
    .row_is0  (row_cnt == 2'd0),
    .hdr_word (hdr_word)
  );

  // Join overhead, payload carried over from the last read, and zero FEC.
  always_comb begin
    case (rg)
      RG_ALIGN, RG_HDR: word_nxt = hdr_word;
      RG_HDR_DAT:       word_nxt = {hdr_word[WORD_W-1:LEAD_W], new_word[WORD_W-1 -: LEAD_W]};
      RG_DAT:           word_nxt = {hold_q, new_word[WORD_W-1 -: LEAD_W]};
      RG_DAT_FEC:       word_nxt = {hold_q[TAIL_W-1 -: LEAD_W], {TAIL_W{1'b0}}};
      default:          word_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_data  <= '0;
      frm_valid <= 1'b0;
      frm_sof   <= 1'b0;
      frm_sod   <= 1'b0;
      frm_eof   <= 1'b0;
    end else begin
      frm_valid <= en;
      frm_sof   <= en && (rg == RG_ALIGN);
      frm_sod   <= en && (rg == RG_HDR_DAT);
      frm_eof   <= frame_done;
      if (en) frm_data <= word_nxt;
    end
  end

endmodule

// File: rtl/otn_frame_builder_chk.sv
module otn_frame_builder_chk
  import otn_bld_pkg::*;
#(
  parameter logic [WORD_W-1:0] FAW = 48'hF6F6F6282828
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [NSRC-1:0]   src_rd,
  input logic [WORD_W-1:0] frm_data,
  input logic              frm_valid,
  input logic              frm_sof,
  input logic              frm_sod,
  input logic              frm_eof,
  input bld_state_e        cur_state,
  input logic              frame_done,
  input logic [MF_W-1:0]   mf
);

  // R7
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_rd));

  // R9
  stall_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> src_rd == '0);

  // R9
  stall_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !frm_valid);

  // R8
  fec_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_FEC || cur_state == ST_DAT_FEC) |-> src_rd == '0);

  // R3
  sof_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_sof |-> frm_data == FAW);

  // R2
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |-> !(frm_sof || frm_sod || frm_eof));

  // R5
  mf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> mf == MF_W'($past(mf) + 1'b1));

  // R11
  wait_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == ST_WAIT |-> src_rd == '0);

endmodule

bind otn_frame_builder otn_frame_builder_chk #(.FAW(FAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .src_rd     (src_rd),
  .frm_data   (frm_data),
  .frm_valid  (frm_valid),
  .frm_sof    (frm_sof),
  .frm_sod    (frm_sod),
  .frm_eof    (frm_eof),
  .cur_state  (cur_state),
  .frame_done (frame_done),
  .mf         (mf_cnt)
);

// File: tb/otn_frame_builder_tb.sv
`timescale 1ns/1ps
module otn_frame_builder_tb_top;

  localparam int PAY = 28;
  localparam int FEC = 16;
  localparam int RW  = (16 + PAY + FEC) / 6;  // 10 words per row
  localparam int DF  = (16 + PAY) / 6;        // boundary word index 7
  localparam int NF  = DF - 2;                // source reads per row
  localparam logic [47:0] PAT = 48'hF6F6F6282828;

  // Scenario table: {route code, stall period (0 = none), frames}
  localparam int NSCN = 5;
  localparam logic [12:0] SCN [NSCN] = '{
    {5'd3,  4'd0, 4'd2},
    {5'd23, 4'd3, 4'd1},
    {5'd0,  4'd7, 4'd2},
    {5'd17, 4'd2, 4'd1},
    {5'd9,  4'd11, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [4:0] route_drv = '0;
  logic [3:0][47:0] src_bus;
  logic [3:0] src_rd;
  logic [47:0] frm_data;
  logic frm_valid, frm_sof, frm_sod, frm_eof;

  int ptr [4];
  int base_m [4];
  int r_m, k_m, mf_m;
  logic [4:0] rlat_m;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  otn_frame_builder #(.PAY_BYTES(PAY), .FEC_BYTES(FEC)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .route_code (route_drv),
    .src_data   (src_bus),
    .src_rd     (src_rd),
    .frm_data   (frm_data),
    .frm_valid  (frm_valid),
    .frm_sof    (frm_sof),
    .frm_sod    (frm_sod),
    .frm_eof    (frm_eof)
  );

  function automatic logic [47:0] src_word(int s, int i);
    logic [31:0] iv;
    logic [31:0] sv;
    iv = 32'(i);
    sv = 32'(s);
    return {4'hA, sv[1:0], 2'b01, iv[7:0], iv[15:0] ^ 16'h3C5A,
            8'(s * 37 + i), 8'(i * 7)};
  endfunction

  always_comb begin
    for (int s = 0; s < 4; s++) src_bus[s] = src_word(s, ptr[s]);
  end

  // Expected byte b of row r, from the requirements.
  function automatic logic [7:0] exp_byte(int r, int b, output string tag);
    logic [47:0] w;
    int p, j;
    if (b < 16) begin
      tag = "R4";
      if (r == 0 && b < 6) begin
        tag = "R3";
        w = PAT;
        return w[47 - 8*b -: 8];
      end
      if (r == 0 && b == 6)  begin tag = "R5"; return 8'(mf_m); end
      if (r == 0 && b == 10) begin tag = "R4 R10"; return {3'b000, rlat_m}; end
      return 8'h00;
    end else if (b < 16 + PAY) begin
      tag = "R6";
      p = b - 16;
      j = p / 6;
      w = src_word(j % 4, base_m[j % 4] + j / 4);
      return w[47 - 8*(p % 6) -: 8];
    end
    tag = "R8";
    return 8'h00;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e);
    logic [3:0] rd_exp, rd_seen;
    logic [7:0] eb [6];
    string tg [6];
    logic e_sof, e_sod, e_eof;
    @(negedge clk);
    en = e;
    #1;
    rd_exp = (e && k_m >= 2 && k_m < DF) ? 4'(1 << ((k_m - 2) % 4)) : 4'h0;
    chk(src_rd == rd_exp, e ? "R7" : "R9", 48'(src_rd), 48'(rd_exp));
    rd_seen = src_rd;
    e_sof = 0; e_sod = 0; e_eof = 0;
    if (e) begin
      if (r_m == 0 && k_m == 0) rlat_m = route_drv;
      for (int i = 0; i < 6; i++) eb[i] = exp_byte(r_m, 6*k_m + i, tg[i]);
      e_sof = (r_m == 0 && k_m == 0);
      e_sod = (k_m == 2);
      e_eof = (r_m == 3 && k_m == RW - 1);
    end
    @(posedge clk);
    #1;
    for (int s = 0; s < 4; s++) if (rd_seen[s]) ptr[s]++;
    chk(frm_valid == e, "R9", 48'(frm_valid), 48'(e));
    if (e) begin
      for (int i = 0; i < 6; i++)
        chk(frm_data[47 - 8*i -: 8] == eb[i], tg[i],
            48'(frm_data[47 - 8*i -: 8]), 48'(eb[i]));
      chk({frm_sof, frm_sod, frm_eof} == {e_sof, e_sod, e_eof}, "R2",
          48'({frm_sof, frm_sod, frm_eof}), 48'({e_sof, e_sod, e_eof}));
      if (k_m == RW - 1) begin
        k_m = 0;
        for (int j = 0; j < NF; j++) base_m[j % 4]++;
        if (r_m == 3) begin
          r_m = 0;
          mf_m = (mf_m + 1) % 256;
        end else r_m++;
      end else k_m++;
    end else begin
      chk({frm_sof, frm_sod, frm_eof} == 3'b000, "R9",
          48'({frm_sof, frm_sod, frm_eof}), 48'h0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(frm_valid == 0 && frm_sof == 0 && frm_sod == 0 && frm_eof == 0,
        "R1", 48'({frm_valid, frm_sof, frm_sod, frm_eof}), 48'h0);
    chk(src_rd == 4'h0, "R1", 48'(src_rd), 48'h0);
    chk(frm_data == 48'h0, "R1", frm_data, 48'h0);
    rst_n = 1'b1;
    r_m = 0; k_m = 0; mf_m = 0; rlat_m = '0;
    for (int s = 0; s < 4; s++) base_m[s] = ptr[s];
    #1;
    chk(frm_valid == 0 && src_rd == 4'h0, "R1",
        48'({frm_valid, src_rd}), 48'h0);
  endtask

  task automatic run_words(input int n, input int stall);
    for (int i = 0; i < n; i++) begin
      if (stall != 0 && (i % stall) == stall - 1) cyc(1'b0);
      cyc(1'b1);
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin ptr[s] = 0; base_m[s] = 0; end
    do_reset();

    // R11: idle cycles, then the first enabled word is the alignment word
    cyc(1'b0);
    cyc(1'b0);
    route_drv = 5'd3;
    cyc(1'b1);
    chk(frm_data == PAT && frm_sof, "R11", frm_data, PAT);
    run_words(4 * RW - 1, 0);

    // Table of scenarios, one loop
    for (int t = 0; t < NSCN; t++) begin
      route_drv = SCN[t][12:8];
      run_words(int'(SCN[t][3:0]) * 4 * RW, int'(SCN[t][7:4]));
    end

    // R10: routing input changes every cycle; only the alignment-cycle value counts
    for (int i = 0; i < 4 * RW; i++) begin
      route_drv = 5'(i % 24);
      cyc(1'b1);
    end
    route_drv = 5'd21;

    // R9: a long stall in the FEC region and one mid-payload
    run_words(RW - 1, 0);
    repeat (3) cyc(1'b0);
    run_words(4, 0);
    repeat (2) cyc(1'b0);
    run_words(3 * RW - 3, 0);

    // R5: run past the wrap of the multiframe count
    run_words(250 * 4 * RW, 0);
    chk(mf_m < 10, "R5", 48'(mf_m), 48'h0);

    // R1: reset in mid-row, then restart from the frame start
    run_words(13, 0);
    do_reset();
    route_drv = 5'd14;
    run_words(2 * 4 * RW, 5);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule